// File: doc/BRIEF.md
# Two-Colour Hardware Cursor Overlay

This block sits in a display's pixel output path and lays a 32x32 two-colour cursor over the picture. The video timing generator supplies the coordinates of each pixel, a valid strobe and the pixel's 8-bit palette index. One clock later the block returns a 9-bit palette entry number. That number is either the incoming index, zero-extended, or one of two overlay entries placed just above the 256 normal ones.

Software shapes and places the cursor through a 32-bit register window. One register holds the position. Two banks of 32 row words hold the shape: a mask bank chooses which cursor pixels are opaque, and a colour bank chooses which of the two overlay entries each opaque pixel uses. The window also holds a miscellaneous word, which reads back with one fixed status bit set. Out of reset the cursor x coordinate is parked far beyond any display width, so nothing shows until software moves the cursor.

Top module: `cursor_overlay`

## Requirements
- R1: After reset the cursor x is 0xF000, the cursor y is 0, every mask and colour row is zero and the miscellaneous word is zero, so every pixel passes through unchanged.
- R2: A write to byte offset 0x8FC sets the cursor x from data bits 31:16 and the cursor y from data bits 15:0.
- R3: A write in offsets 0x900..0x97F stores a mask row, and a write in 0x980..0x9FF stores a colour row. In both cases the row number is (offset - base) >> 2.
- R4: Bit 31 of a row word belongs to cursor column 0, which is the leftmost column, and bit 0 belongs to column 31.
- R5: Where the mask bit is set, the output is entry 259 (0x103) if the colour bit is set and entry 258 (0x102) if it is clear. Where the mask bit is clear, the output is {0, pixel index}.
- R6: The cursor covers only rows y..y+31 and columns x..x+31. Any pixel outside that window passes through.
- R7: A pixel with x at or beyond the display width is never overlaid. A cursor whose x is at or beyond the width therefore draws nothing.
- R8: A write to offset 0x818 stores the full 32-bit miscellaneous word. A read of 0x818 returns that word with bit 25 forced to one.
- R9: Every offset other than 0x818 reads zero. That includes the position and bitmap offsets. Writes to unlisted offsets change nothing.
- R10: The output entry and the output valid strobe follow the pixel inputs with a latency of exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe, 32-bit access |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on reg_addr_i |
| pix_valid_i | input | 1 | Pixel strobe from the timing generator |
| pix_x_i | input | 16 | Pixel column |
| pix_y_i | input | 16 | Pixel row |
| pix_index_i | input | 8 | Underlying palette index |
| pix_valid_o | output | 1 | Delayed pixel strobe |
| pix_entry_o | output | 9 | Palette entry number to look up |

## Verification
The checker assumes that every register access is a whole 32-bit word. It also assumes that the pixel inputs are stable around the clock edge that samples them. Under those conditions, an output entry with bit 8 set can only be 258 or 259. A pixel column at or past the display width must come back as its own index. The bench changes inputs only on falling edges. It uses only word-aligned offsets, and it deliberately presents columns past the width so that the clipping property is exercised.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam logic [AW-1:0] OFF_MISC  = 12'h818;
  localparam logic [AW-1:0] OFF_POS   = 12'h8FC;
  localparam logic [AW-1:0] OFF_MASK  = 12'h900;
  localparam logic [AW-1:0] OFF_COLR  = 12'h980;
  localparam logic [DW-1:0] MISC_FIXED = 32'h0200_0000;
  localparam logic [15:0]   PARK_X     = 16'hF000;
endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
  import cursor_pkg::*;
#(
  parameter int CW = 16,
  parameter int N  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic [CW-1:0]      cur_x_o,
  output logic [CW-1:0]      cur_y_o,
  output logic [N-1:0][N-1:0] mask_o,
  output logic [N-1:0][N-1:0] colr_o
);
  localparam int RIW = $clog2(N);
  localparam logic [AW-1:0] MASK_END = AW'(OFF_MASK + 4 * N);
  localparam logic [AW-1:0] COLR_END = AW'(OFF_COLR + 4 * N);

  logic [AW-1:0] mask_off, colr_off;
  logic          mask_sel, colr_sel;
  logic [RIW-1:0] mask_row, colr_row;
  logic [DW-1:0] misc_q;

  assign mask_off = addr_i - OFF_MASK;
  assign colr_off = addr_i - OFF_COLR;
  assign mask_sel = we_i && (addr_i >= OFF_MASK) && (addr_i < MASK_END);
  assign colr_sel = we_i && (addr_i >= OFF_COLR) && (addr_i < COLR_END);
  assign mask_row = mask_off[RIW+1:2];
  assign colr_row = colr_off[RIW+1:2];

  for (genvar r = 0; r < N; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_o[r] <= '0;
        colr_o[r] <= '0;
      end else begin
        if (mask_sel && mask_row == RIW'(r)) mask_o[r] <= wdata_i[N-1:0];
        if (colr_sel && colr_row == RIW'(r)) colr_o[r] <= wdata_i[N-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_x_o <= CW'(PARK_X);
      cur_y_o <= '0;
      misc_q  <= '0;
    end else if (we_i) begin
      if (addr_i == OFF_POS) begin
        cur_x_o <= wdata_i[16 +: CW];
        cur_y_o <= wdata_i[0 +: CW];
      end
      if (addr_i == OFF_MISC) misc_q <= wdata_i;
    end
  end

  assign rdata_o = (addr_i == OFF_MISC) ? (misc_q | MISC_FIXED) : '0;
endmodule

// File: rtl/cursor_pix.sv
module cursor_pix #(
  parameter int CW     = 16,
  parameter int N      = 32,
  parameter int IDX_W  = 8,
  parameter int DISP_W = 640
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [CW-1:0]       x_i,
  input  logic [CW-1:0]       y_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [CW-1:0]       cur_x_i,
  input  logic [CW-1:0]       cur_y_i,
  input  logic [N-1:0][N-1:0] mask_i,
  input  logic [N-1:0][N-1:0] colr_i,
  output logic                valid_o,
  output logic [IDX_W:0]      entry_o
);
  localparam int RIW = $clog2(N);
  localparam logic [IDX_W:0] ENT_BG = (IDX_W+1)'((1 << IDX_W) + 2);
  localparam logic [IDX_W:0] ENT_FG = (IDX_W+1)'((1 << IDX_W) + 3);

  logic [CW:0]    dx, dy;
  logic           in_win, on_scr, hit, sel_fg;
  logic [RIW-1:0] col, row, bitpos;

  // wrap-around of negative offsets makes them large, so one compare per axis
  assign dx     = {1'b0, x_i} - {1'b0, cur_x_i};
  assign dy     = {1'b0, y_i} - {1'b0, cur_y_i};
  assign in_win = (dx < (CW+1)'(N)) && (dy < (CW+1)'(N));
  assign on_scr = x_i < CW'(DISP_W);
  assign col    = dx[RIW-1:0];
  assign row    = dy[RIW-1:0];
  assign bitpos = RIW'(N - 1) - col;
  assign hit    = in_win && on_scr && mask_i[row][bitpos];
  assign sel_fg = colr_i[row][bitpos];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      entry_o <= '0;
    end else begin
      valid_o <= valid_i;
      entry_o <= hit ? (sel_fg ? ENT_FG : ENT_BG) : {1'b0, idx_i};
    end
  end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int CW     = 16,
  parameter int N      = 32,
  parameter int IDX_W  = 8,
  parameter int DISP_W = 640
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  input  logic             pix_valid_i,
  input  logic [CW-1:0]    pix_x_i,
  input  logic [CW-1:0]    pix_y_i,
  input  logic [IDX_W-1:0] pix_index_i,
  output logic             pix_valid_o,
  output logic [IDX_W:0]   pix_entry_o
);
  logic [CW-1:0]       cur_x, cur_y;
  logic [N-1:0][N-1:0] mask, colr;

  cursor_regs #(.CW(CW), .N(N)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .cur_x_o (cur_x),
    .cur_y_o (cur_y),
    .mask_o  (mask),
    .colr_o  (colr)
  );

  cursor_pix #(.CW(CW), .N(N), .IDX_W(IDX_W), .DISP_W(DISP_W)) u_pix (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (pix_valid_i),
    .x_i     (pix_x_i),
    .y_i     (pix_y_i),
    .idx_i   (pix_index_i),
    .cur_x_i (cur_x),
    .cur_y_i (cur_y),
    .mask_i  (mask),
    .colr_i  (colr),
    .valid_o (pix_valid_o),
    .entry_o (pix_entry_o)
  );
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk
  import cursor_pkg::*;
#(
  parameter int CW     = 16,
  parameter int IDX_W  = 8,
  parameter int DISP_W = 640
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [AW-1:0]    reg_addr_i,
  input logic [DW-1:0]    reg_rdata_o,
  input logic             pix_valid_i,
  input logic [CW-1:0]    pix_x_i,
  input logic [IDX_W-1:0] pix_index_i,
  input logic             pix_valid_o,
  input logic [IDX_W:0]   pix_entry_o
);
  p_overlay_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_entry_o[IDX_W] |-> (pix_entry_o[IDX_W-1:2] == '0) && pix_entry_o[1]);

  p_clip_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_x_i >= CW'(DISP_W)) |=> (pix_entry_o == {1'b0, $past(pix_index_i)}));

  p_misc_bit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == OFF_MISC) |-> reg_rdata_o[25]);

  p_unmapped_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i != OFF_MISC) |-> (reg_rdata_o == '0));

  p_valid_rise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i |=> pix_valid_o);

  p_valid_fall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |=> !pix_valid_o);
endmodule

bind cursor_overlay cursor_overlay_chk #(.CW(CW), .IDX_W(IDX_W), .DISP_W(DISP_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .pix_valid_i (pix_valid_i),
  .pix_x_i     (pix_x_i),
  .pix_index_i (pix_index_i),
  .pix_valid_o (pix_valid_o),
  .pix_entry_o (pix_entry_o)
);

// File: tb/cursor_overlay_tb.sv
module cursor_overlay_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [11:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        pix_valid_i = 1'b0;
  logic [15:0] pix_x_i = '0;
  logic [15:0] pix_y_i = '0;
  logic [7:0]  pix_index_i = '0;
  logic        pix_valid_o;
  logic [8:0]  pix_entry_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cursor_overlay dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .pix_valid_i(pix_valid_i), .pix_x_i(pix_x_i), .pix_y_i(pix_y_i),
    .pix_index_i(pix_index_i), .pix_valid_o(pix_valid_o),
    .pix_entry_o(pix_entry_o)
  );

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk_i);
    reg_addr_i = a;
    #1;
    checks++;
    if (reg_rdata_o !== exp) begin
      errors++;
      $display("FAIL %s: read 0x%03h got 0x%08h expected 0x%08h", tag, a, reg_rdata_o, exp);
    end
  endtask

  task automatic px_chk(input int x, input int y, input logic [7:0] idx,
                        input logic [8:0] exp, input string tag);
    @(negedge clk_i);
    pix_valid_i = 1'b1; pix_x_i = 16'(x); pix_y_i = 16'(y); pix_index_i = idx;
    @(negedge clk_i);
    checks++;
    if (pix_entry_o !== exp || pix_valid_o !== 1'b1) begin
      errors++;
      $display("FAIL %s: pixel (%0d,%0d) got entry 0x%03h valid %b expected 0x%03h valid 1",
               tag, x, y, pix_entry_o, pix_valid_o, exp);
    end
  endtask

  task automatic t_reset;
    rd_chk(12'h818, 32'h0200_0000, "R1");
    px_chk(0, 0, 8'h5A, 9'h05A, "R1");
    px_chk(16'hF000, 0, 8'hAA, 9'h0AA, "R1");
  endtask

  task automatic t_shape;
    wr(12'h8FC, {16'd100, 16'd50});
    wr(12'h900, 32'h8000_0001);
    wr(12'h980, 32'h8000_0000);
    px_chk(100, 50, 8'h11, 9'h103, "R2 R4 R5 fg");
    px_chk(131, 50, 8'h11, 9'h102, "R4 R5 bg");
    px_chk(101, 50, 8'h22, 9'h022, "R5 transparent");
  endtask

  task automatic t_rows;
    wr(12'h914, 32'h0001_0000);
    wr(12'h994, 32'h0001_0000);
    wr(12'h97C, 32'hFFFF_FFFF);
    px_chk(115, 55, 8'h33, 9'h103, "R3 row5");
    px_chk(115, 54, 8'h34, 9'h034, "R3 row4");
    px_chk(131, 81, 8'h35, 9'h102, "R6 last row");
    px_chk(132, 81, 8'h36, 9'h036, "R6 right of window");
    px_chk(100, 82, 8'h37, 9'h037, "R6 below window");
    px_chk(100, 49, 8'h38, 9'h038, "R6 above window");
    px_chk(99, 50, 8'h39, 9'h039, "R6 left of window");
  endtask

  task automatic t_clip;
    wr(12'h900, 32'hFFFF_FFFF);
    wr(12'h980, 32'hFFFF_FFFF);
    wr(12'h8FC, {16'd630, 16'd10});
    px_chk(639, 10, 8'h41, 9'h103, "R7 last column");
    px_chk(640, 10, 8'h42, 9'h042, "R7 at width");
    px_chk(661, 10, 8'h43, 9'h043, "R7 beyond width");
    wr(12'h8FC, {16'd640, 16'd10});
    px_chk(640, 10, 8'h44, 9'h044, "R7 parked at width");
    px_chk(650, 10, 8'h45, 9'h045, "R7 parked at width");
  endtask

  task automatic t_misc;
    wr(12'h818, 32'h1000_5678);
    rd_chk(12'h818, 32'h1200_5678, "R8");
  endtask

  task automatic t_unmapped;
    wr(12'h8FC, 32'h0000_0000);
    px_chk(5, 0, 8'h50, 9'h103, "R9 setup");
    rd_chk(12'h8FC, 32'h0, "R9 pos reads zero");
    rd_chk(12'h900, 32'h0, "R9 mask reads zero");
    rd_chk(12'h004, 32'h0, "R9 unlisted reads zero");
    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'h8F8, {16'd300, 16'd300});
    wr(12'hA00, 32'h0);
    px_chk(5, 0, 8'h51, 9'h103, "R9 writes ignored");
    rd_chk(12'h818, 32'h1200_5678, "R9 misc untouched");
  endtask

  task automatic t_valid;
    @(negedge clk_i);
    pix_valid_i = 1'b0; pix_x_i = 16'd700; pix_index_i = 8'h66;
    @(negedge clk_i);
    checks++;
    if (pix_valid_o !== 1'b0 || pix_entry_o !== 9'h066) begin
      errors++;
      $display("FAIL R10: valid %b entry 0x%03h expected valid 0 entry 0x066",
               pix_valid_o, pix_entry_o);
    end
    pix_valid_i = 1'b1; pix_index_i = 8'h67;
    #1;
    checks++;
    if (pix_entry_o !== 9'h066) begin
      errors++;
      $display("FAIL R10: entry changed before edge, got 0x%03h expected 0x066", pix_entry_o);
    end
    @(negedge clk_i);
    checks++;
    if (pix_valid_o !== 1'b1 || pix_entry_o !== 9'h067) begin
      errors++;
      $display("FAIL R10: valid %b entry 0x%03h expected valid 1 entry 0x067",
               pix_valid_o, pix_entry_o);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_shape();
    t_rows();
    t_clip();
    t_misc();
    t_unmapped();
    t_valid();
    repeat (2) @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule